// File: doc/BRIEF.md
# Boundary Scan Controller with Shared Programming Pins

This block puts a boundary-scan register chain and its test access port (TAP) controller in front of a group of programmable I/O cells. A tri-state cell has three chain cells: one for its pad input, one for its output data and one for its output enable. An input-only pin has one chain cell, for its pad value. The controller decodes the three mandatory instructions. SAMPLE captures the state at the pins while the core keeps control of them. EXTEST hands the pad drivers to the chain's update latches. BYPASS shortens the serial path to one bit.

A mode-select pin decides who owns the four serial pins. When it is high, the pins are TMS, TDI, TDO and TCK for the TAP. When it is low, the pins are routed to a programming engine. Only a stub interface to that engine is modelled here. On the falling edge of the mode pin, and for as long as it stays low, every I/O driver is in high impedance and the TAP holds its state. An active-low asynchronous TAP reset returns the controller to Test-Logic-Reset.

Top module: `pin_scan_ctl`

## Requirements
- R1: Asserting `trst_n` low asynchronously puts the TAP in Test-Logic-Reset, with BYPASS as the current instruction, pads following the core and `tdo_oe` low.
- R2: In Capture-IR the 4-bit instruction shift register loads 0001. Its bit 0 leaves TDO first.
- R3: BYPASS (1111) selects a one-bit register that captures 0. TDI data therefore reappears on TDO one shift later.
- R4: Every instruction code other than 0000 and 0010 behaves as BYPASS.
- R5: SAMPLE (0010) captures the chain in this order: for tri-state cell i, bit 3i is `pad_in[i]`, bit 3i+1 is `core_out[i]` and bit 3i+2 is `core_oe[i]`; input-only pin j goes to bit 3*N_TRI+j. Bit 0 is shifted out first and TDI enters at the top bit. During SAMPLE the pads keep following the core.
- R6: Under EXTEST (0000), `pad_out[i]` and `pad_oe[i]` come from the update latches of chain bits 3i+1 and 3i+2. The update latches load on the falling TCK edge in Update-DR. The core values are ignored.
- R7: The chain is 3*N_TRI+N_IN bits long, so data on TDI emerges on TDO after exactly that many shifts.
- R8: In scan mode, `tdo_oe` is high only while the TAP is in Shift-IR or Shift-DR. TDO changes on the falling TCK edge.
- R9: While `scan_en` is low, every `pad_oe` bit is 0, including under EXTEST with the enable latches set.
- R10: While `scan_en` is low, the pins map as follows and the TAP and its latches keep their state: `prog_sclk`/`prog_ctl`/`prog_sdi` follow the clock, TMS and TDI pins; `tdo_sdo`/`tdo_oe` follow `prog_sdo`/`prog_sdo_oe`; `prog_active` is high. While `scan_en` is high, the three stub outputs stay low.
- R11: Five TCK cycles with TMS high reach Test-Logic-Reset from any state and restore BYPASS, so the pads follow the core again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| scan_en | input | 1 | Mode select: 1 = scan port, 0 = programming port with I/O in high impedance |
| trst_n | input | 1 | Asynchronous active-low TAP reset |
| tck_sclk | input | 1 | Shared serial clock pin |
| tms_mode | input | 1 | Shared mode/control pin |
| tdi_sdi | input | 1 | Shared serial data input pin |
| tdo_sdo | output | 1 | Shared serial data output pin value |
| tdo_oe | output | 1 | Driver enable for the serial output pin |
| core_out | input | N_TRI | Core output data for each tri-state cell |
| core_oe | input | N_TRI | Core output enable for each tri-state cell |
| pad_in | input | N_TRI | Pad input value of each tri-state cell |
| in_pin | input | N_IN | Pad value of each input-only pin |
| pad_out | output | N_TRI | Data driven to each tri-state pad |
| pad_oe | output | N_TRI | Driver enable of each tri-state pad |
| prog_active | output | 1 | Programming engine owns the shared pins |
| prog_sclk | output | 1 | Clock to the programming engine |
| prog_ctl | output | 1 | Control line to the programming engine |
| prog_sdi | output | 1 | Serial data to the programming engine |
| prog_sdo | input | 1 | Serial data from the programming engine |
| prog_sdo_oe | input | 1 | Output enable from the programming engine |

## Verification
A TAP that is in the wrong state shows up at the next scan. The TDO bits come out shifted, or `tdo_oe` rises outside a shift, at the first falling TCK edge after the bad transition. A wrong instruction decode is seen as soon as the pads are updated. The pads either stay with the core when they should follow the update latches, or leave the core when they should stay with it. A fault in the chain order or length changes the captured word, visible bit by bit on TDO within one scan of 3*N_TRI+N_IN shifts. A leak from the mode multiplexer shows the same cycle as an enabled pad or a wrong serial output while `scan_en` is low.

// File: rtl/pin_scan_ctl.sv
module pin_scan_ctl #(
  parameter int N_TRI = 4,
  parameter int N_IN  = 2
) (
  input  logic             scan_en,
  input  logic             trst_n,
  input  logic             tck_sclk,
  input  logic             tms_mode,
  input  logic             tdi_sdi,
  output logic             tdo_sdo,
  output logic             tdo_oe,
  input  logic [N_TRI-1:0] core_out,
  input  logic [N_TRI-1:0] core_oe,
  input  logic [N_TRI-1:0] pad_in,
  input  logic [N_IN-1:0]  in_pin,
  output logic [N_TRI-1:0] pad_out,
  output logic [N_TRI-1:0] pad_oe,
  output logic             prog_active,
  output logic             prog_sclk,
  output logic             prog_ctl,
  output logic             prog_sdi,
  input  logic             prog_sdo,
  input  logic             prog_sdo_oe
);
  localparam int CHAIN = 3*N_TRI + N_IN;
  localparam logic [3:0] OP_EXTEST = 4'b0000;
  localparam logic [3:0] OP_SAMPLE = 4'b0010;
  localparam logic [3:0] OP_BYPASS = 4'b1111;

  typedef enum logic [3:0] {
    EX2_DR = 4'h0, EX1_DR = 4'h1, SH_DR  = 4'h2, PAU_DR = 4'h3,
    SEL_IR = 4'h4, UPD_DR = 4'h5, CAP_DR = 4'h6, SEL_DR = 4'h7,
    EX2_IR = 4'h8, EX1_IR = 4'h9, SH_IR  = 4'hA, PAU_IR = 4'hB,
    RTI    = 4'hC, UPD_IR = 4'hD, CAP_IR = 4'hE, TLR    = 4'hF
  } tap_e;

  tap_e st, nx;
  logic [3:0]       ir, ir_sr;
  logic             byp, tdo_r, tdo_en_r;
  logic [CHAIN-1:0] bsr, cap;
  logic [N_TRI-1:0] upd_out, upd_oe;
  logic             sel_bsr, extest;

  assign extest  = (ir == OP_EXTEST);
  assign sel_bsr = extest || (ir == OP_SAMPLE);

  always_comb begin
    unique case (st)
      TLR:    nx = tms_mode ? TLR    : RTI;
      RTI:    nx = tms_mode ? SEL_DR : RTI;
      SEL_DR: nx = tms_mode ? SEL_IR : CAP_DR;
      CAP_DR: nx = tms_mode ? EX1_DR : SH_DR;
      SH_DR:  nx = tms_mode ? EX1_DR : SH_DR;
      EX1_DR: nx = tms_mode ? UPD_DR : PAU_DR;
      PAU_DR: nx = tms_mode ? EX2_DR : PAU_DR;
      EX2_DR: nx = tms_mode ? UPD_DR : SH_DR;
      UPD_DR: nx = tms_mode ? SEL_DR : RTI;
      SEL_IR: nx = tms_mode ? TLR    : CAP_IR;
      CAP_IR: nx = tms_mode ? EX1_IR : SH_IR;
      SH_IR:  nx = tms_mode ? EX1_IR : SH_IR;
      EX1_IR: nx = tms_mode ? UPD_IR : PAU_IR;
      PAU_IR: nx = tms_mode ? EX2_IR : PAU_IR;
      EX2_IR: nx = tms_mode ? UPD_IR : SH_IR;
      default: nx = tms_mode ? SEL_DR : RTI;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_TRI; gi++) begin : g_tri
      assign cap[3*gi]   = pad_in[gi];
      assign cap[3*gi+1] = core_out[gi];
      assign cap[3*gi+2] = core_oe[gi];
      assign pad_out[gi] = extest ? upd_out[gi] : core_out[gi];
      assign pad_oe[gi]  = scan_en & (extest ? upd_oe[gi] : core_oe[gi]);
    end
    for (gi = 0; gi < N_IN; gi++) begin : g_in
      assign cap[3*N_TRI+gi] = in_pin[gi];
    end
  endgenerate

  always_ff @(posedge tck_sclk or negedge trst_n) begin
    if (!trst_n) st <= TLR;
    else if (scan_en) st <= nx;
  end

  always_ff @(posedge tck_sclk or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= '0;
      byp   <= 1'b0;
      bsr   <= '0;
    end else if (scan_en) begin
      case (st)
        CAP_IR: ir_sr <= 4'b0001;
        SH_IR:  ir_sr <= {tdi_sdi, ir_sr[3:1]};
        CAP_DR: begin
          byp <= 1'b0;
          if (sel_bsr) bsr <= cap;
        end
        SH_DR: begin
          byp <= tdi_sdi;
          if (sel_bsr) bsr <= {tdi_sdi, bsr[CHAIN-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(negedge tck_sclk or negedge trst_n) begin
    if (!trst_n) begin
      ir       <= OP_BYPASS;
      upd_out  <= '0;
      upd_oe   <= '0;
      tdo_r    <= 1'b0;
      tdo_en_r <= 1'b0;
    end else if (scan_en) begin
      tdo_en_r <= (st == SH_DR) || (st == SH_IR);
      tdo_r    <= (st == SH_IR) ? ir_sr[0] : (sel_bsr ? bsr[0] : byp);
      if (st == TLR) ir <= OP_BYPASS;
      else if (st == UPD_IR) ir <= ir_sr;
      if (st == UPD_DR && sel_bsr) begin
        for (int i = 0; i < N_TRI; i++) begin
          upd_out[i] <= bsr[3*i+1];
          upd_oe[i]  <= bsr[3*i+2];
        end
      end
    end
  end

  assign tdo_sdo     = scan_en ? tdo_r    : prog_sdo;
  assign tdo_oe      = scan_en ? tdo_en_r : prog_sdo_oe;
  assign prog_active = ~scan_en;
  assign prog_sclk   = ~scan_en & tck_sclk;
  assign prog_ctl    = ~scan_en & tms_mode;
  assign prog_sdi    = ~scan_en & tdi_sdi;
endmodule

// File: rtl/pin_scan_ctl_chk.sv
module pin_scan_ctl_chk #(
  parameter int N_TRI = 4
) (
  input logic             clk,
  input logic             trst_n,
  input logic             scan_en,
  input logic [3:0]       st,
  input logic [3:0]       ir_sr,
  input logic [N_TRI-1:0] pad_oe,
  input logic [N_TRI-1:0] pad_out,
  input logic [N_TRI-1:0] core_out,
  input logic             tdo_sdo,
  input logic             tdo_oe,
  input logic             prog_sdo,
  input logic             prog_sdo_oe
);
  p_hiz_prog_r9: assert property (@(posedge clk) disable iff (!trst_n)
    !scan_en |-> (pad_oe == '0));

  p_tdo_route_r10: assert property (@(posedge clk) disable iff (!trst_n)
    !scan_en |-> (tdo_sdo == prog_sdo && tdo_oe == prog_sdo_oe));

  p_ir_capture_r2: assert property (@(posedge clk) disable iff (!trst_n)
    (scan_en && st == 4'hE) |=> (ir_sr == 4'b0001));

  p_tdo_quiet_r8: assert property (@(posedge clk) disable iff (!trst_n)
    (scan_en && $past(scan_en) && tdo_oe) |-> (st == 4'h2 || st == 4'hA));

  p_tlr_core_r11: assert property (@(posedge clk) disable iff (!trst_n)
    (st == 4'hF && $past(st) == 4'hF) |-> (pad_out == core_out));
endmodule

bind pin_scan_ctl pin_scan_ctl_chk #(.N_TRI(N_TRI)) u_chk (
  .clk(tck_sclk), .trst_n(trst_n), .scan_en(scan_en), .st(st), .ir_sr(ir_sr),
  .pad_oe(pad_oe), .pad_out(pad_out), .core_out(core_out),
  .tdo_sdo(tdo_sdo), .tdo_oe(tdo_oe), .prog_sdo(prog_sdo), .prog_sdo_oe(prog_sdo_oe)
);

// File: tb/pin_scan_ctl_bench.sv
module pin_scan_ctl_bench;
  localparam int NT = 4;
  localparam int NI = 2;
  localparam int CH = 3*NT + NI;

  logic clk = 1'b0;
  logic scan_en = 1'b1, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo_sdo, tdo_oe;
  logic [NT-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NI-1:0] in_pin = '0;
  logic [NT-1:0] pad_out, pad_oe;
  logic prog_active, prog_sclk, prog_ctl, prog_sdi;
  logic prog_sdo = 1'b0, prog_sdo_oe = 1'b0;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pin_scan_ctl #(.N_TRI(NT), .N_IN(NI)) u_pin_scan_ctl (
    .scan_en(scan_en), .trst_n(trst_n), .tck_sclk(clk), .tms_mode(tms), .tdi_sdi(tdi),
    .tdo_sdo(tdo_sdo), .tdo_oe(tdo_oe), .core_out(core_out), .core_oe(core_oe),
    .pad_in(pad_in), .in_pin(in_pin), .pad_out(pad_out), .pad_oe(pad_oe),
    .prog_active(prog_active), .prog_sclk(prog_sclk), .prog_ctl(prog_ctl),
    .prog_sdi(prog_sdi), .prog_sdo(prog_sdo), .prog_sdo_oe(prog_sdo_oe));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge clk); #2;
    o = tdo_sdo; tms = m; tdi = d;
    @(posedge clk); #1;
  endtask

  task automatic go_rti();
    logic o;
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o);
    tick(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [3:0] v, output logic [3:0] q, output logic oe_seen);
    logic o;
    tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    oe_seen = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(k == 3, v[k], o);
      q[k] = o;
      oe_seen = oe_seen & tdo_oe;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic scan_dr(input logic [63:0] v, input int n, output logic [63:0] q);
    logic o;
    q = '0;
    tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
    for (int k = 0; k < n; k++) begin
      tick(k == n-1, v[k], o);
      q[k] = o;
    end
    tick(1, 0, o); tick(0, 0, o);
  endtask

  task automatic t_reset();
    logic [63:0] q;
    logic [3:0] qi;
    logic oe;
    core_out = 4'b1001; core_oe = 4'b0111;
    go_rti();
    scan_ir(4'b0000, qi, oe);
    #3 trst_n = 1'b0;
    #1;
    chk("R1 pads follow core after reset", {pad_out, pad_oe}, {4'b1001, 4'b0111});
    chk("R1 tdo_oe low in reset", tdo_oe, 0);
    @(negedge clk); trst_n = 1'b1;
    go_rti();
    chk("R8 tdo_oe low in idle", tdo_oe, 0);
    scan_dr(64'hB5, 8, q);
    chk("R3 bypass after reset delays by one", q[7:0], 8'h6A);
  endtask

  task automatic t_ir_capture();
    logic [3:0] qi;
    logic oe;
    scan_ir(4'b0101, qi, oe);
    chk("R2 IR capture pattern", qi, 4'b0001);
    chk("R8 tdo_oe high during Shift-IR", oe, 1);
    chk("R8 tdo_oe low after IR scan", tdo_oe, 0);
  endtask

  task automatic t_other_code();
    logic [63:0] q;
    scan_dr(64'h3C, 8, q);
    chk("R4 unused code 0101 acts as bypass", q[7:0], 8'h78);
    chk("R4 pads follow core", {pad_out, pad_oe}, {core_out, core_oe});
  endtask

  task automatic t_sample();
    logic [3:0] qi;
    logic oe;
    logic [63:0] q, e, pat;
    core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011; in_pin = 2'b10;
    scan_ir(4'b0010, qi, oe);
    e = '0;
    for (int i = 0; i < NT; i++) begin
      e[3*i] = pad_in[i]; e[3*i+1] = core_out[i]; e[3*i+2] = core_oe[i];
    end
    for (int j = 0; j < NI; j++) e[3*NT+j] = in_pin[j];
    pat = 64'h2D3B;
    scan_dr(pat, 2*CH, q);
    chk("R5 sample capture order", q[CH-1:0], e[CH-1:0]);
    chk("R7 chain length", q[2*CH-1:CH], pat[CH-1:0]);
    chk("R5 pads follow core during sample", {pad_out, pad_oe}, {4'b1010, 4'b0110});
  endtask

  task automatic t_extest();
    logic [3:0] qi;
    logic oe;
    logic [63:0] q, v;
    logic [NT-1:0] po, pe;
    po = 4'b0110; pe = 4'b1101;
    scan_ir(4'b0000, qi, oe);
    v = '0;
    for (int i = 0; i < NT; i++) begin v[3*i+1] = po[i]; v[3*i+2] = pe[i]; end
    scan_dr(v, CH, q);
    chk("R6 extest drives pad_out", pad_out, po);
    chk("R6 extest drives pad_oe", pad_oe, pe);
    core_out = ~core_out; core_oe = ~core_oe;
    #1;
    chk("R6 core ignored under extest", {pad_out, pad_oe}, {po, pe});
  endtask

  task automatic t_prog();
    @(negedge clk); #2;
    scan_en = 1'b0; prog_sdo = 1'b1; prog_sdo_oe = 1'b1; tms = 1'b1; tdi = 1'b1;
    #1;
    chk("R9 all pads high impedance in programming mode", pad_oe, '0);
    chk("R10 serial out from programming engine", {tdo_sdo, tdo_oe, prog_active}, 3'b111);
    chk("R10 ctl and sdi routed", {prog_ctl, prog_sdi}, 2'b11);
    @(posedge clk); #2;
    chk("R10 sclk routed high", prog_sclk, 1);
    @(negedge clk); #2;
    chk("R10 sclk routed low", prog_sclk, 0);
    prog_sdo = 1'b0; prog_sdo_oe = 1'b0;
    #1;
    chk("R10 serial out follows engine", {tdo_sdo, tdo_oe}, 2'b00);
    repeat (6) @(posedge clk);
    @(negedge clk); #2;
    tms = 1'b0; tdi = 1'b0;
    scan_en = 1'b1;
    #1;
    chk("R10 stub quiet in scan mode", {prog_sclk, prog_ctl, prog_sdi, prog_active}, 4'b0000);
    chk("R10 TAP held extest through programming mode", {pad_out, pad_oe}, {4'b0110, 4'b1101});
  endtask

  task automatic t_tlr();
    logic o;
    for (int k = 0; k < 5; k++) tick(1'b1, 1'b0, o);
    @(negedge clk); #2;
    chk("R11 five TMS-high cycles restore core drive", {pad_out, pad_oe}, {core_out, core_oe});
    tick(1'b0, 1'b0, o);
  endtask

  initial begin
    #1;
    chk("R1 tdo_oe low at reset", tdo_oe, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); trst_n = 1'b1;
    t_reset();
    t_ir_capture();
    t_other_code();
    t_sample();
    t_extest();
    t_prog();
    t_tlr();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule